// File: doc/BRIEF.md
# Instruction Bucket Classifier and Pattern Matcher

This block sits at the front of an instruction decoder. Each cycle that `in_valid` is high it takes a 32-bit instruction word and sorts it into one of 64 decode buckets. The bucket number is taken from a different slice of the low half-word, chosen by the format class that bits 10:6 encode. From the same word it cuts out the three standard operand fields, and it flags a word that is entirely zero, which downstream logic treats as a stop request.

Each bucket owns a short list of opcode/mask patterns, loaded through a dedicated write port. The block searches the selected bucket's list in slot order. It reports the first slot where the word ANDed with the slot's mask equals the slot's opcode. When no loaded slot agrees, it reports a miss. All results appear on registered outputs one cycle after the strobe.

Top module: `insn_bucket_decode`

## Requirements
- R1: When bits 10:9 are 00, or bits 10:8 are 010 or 110, or bits 10:7 are 1110, or no other rule applies, the bucket is bits 10:5 of the word.
- R2: When bits 10:8 are 011, 100 or 101, the bucket is bits 10:7, zero-extended to 6 bits.
- R3: When bits 10:6 are 11110, the bucket is bits 10:6, zero-extended to 6 bits.
- R4: `res_f0` carries bits 4:0, `res_f1` carries bits 15:11 and `res_f2` carries bits 31:16 of the strobed word.
- R5: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. Bucket and field outputs hold their values while no strobe arrives.
- R6: When several loaded slots of the bucket match, `res_slot` reports the lowest-numbered one and `res_hit` is high.
- R7: With `res_valid` high, exactly one of `res_hit` and `res_miss` is high. `res_miss` is high when no loaded slot matches. Both are low while `res_valid` is low.
- R8: `res_zero` is high for a result whose word was all zeros. Such a word falls in bucket 0.
- R9: A write with `tw_en` high stores opcode and mask into slot `tw_slot` of bucket `tw_bucket` and marks that slot loaded, replacing any earlier pattern there. A lookup in the same cycle as the write still sees the earlier contents.
- R10: Reset (`rst` high, synchronous) clears `res_valid` and marks every slot of every bucket as not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 32 | Instruction word |
| tw_en | input | 1 | Pattern table write enable |
| tw_bucket | input | 6 | Bucket being written |
| tw_slot | input | 2 | Slot being written |
| tw_opcode | input | 32 | Opcode value for the slot |
| tw_mask | input | 32 | Mask for the slot |
| res_valid | output | 1 | Result valid |
| res_bucket | output | 6 | Bucket index |
| res_f0 | output | 5 | Operand field, bits 4:0 |
| res_f1 | output | 5 | Operand field, bits 15:11 |
| res_f2 | output | 16 | Operand field, bits 31:16 |
| res_hit | output | 1 | A loaded slot matched |
| res_slot | output | 2 | First matching slot |
| res_miss | output | 1 | No loaded slot matched |
| res_zero | output | 1 | Word was all zeros |

## Verification
Two situations are hard to reach from the ports. The first is a slot priority conflict, where two loaded slots of one bucket both accept the word. The second is a lookup that shares its cycle with a write to the very slot it would hit. The stimulus loads a bucket with a narrow pattern in slot 0 and a broad one in slot 2. It leaves slot 1 empty, so that one word reaches both patterns and a neighbouring word reaches only the broad one. Separately, it presents a word and a write to that word's bucket on the same edge, then repeats the lookup alone.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  localparam int WORD_W = 32;
  localparam int BKT_W  = 6;
  localparam int F0_W   = 5;
  localparam int F1_W   = 5;
  localparam int F2_W   = 16;
endpackage

// File: rtl/ibd_bucket_sel.sv
module ibd_bucket_sel
  import ibd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [BKT_W-1:0]  bucket
);
  logic [1:0] cls2;
  logic [2:0] cls3;
  logic [3:0] cls4;
  logic [4:0] cls5;
  logic       wide_sel;
  logic       mid_sel;
  logic       narrow_sel;

  assign cls2 = word[10:9];
  assign cls3 = word[10:8];
  assign cls4 = word[10:7];
  assign cls5 = word[10:6];

  // Wide rule has priority over the two shorter slices.
  assign wide_sel   = (cls2 == 2'b00) || (cls3 == 3'b010) ||
                      (cls3 == 3'b110) || (cls4 == 4'b1110);
  assign narrow_sel = (cls3 == 3'b011) || (cls3 == 3'b100) ||
                      (cls3 == 3'b101);
  assign mid_sel    = (cls5 == 5'b11110);

  always_comb begin
    if (wide_sel)
      bucket = word[10:5];
    else if (narrow_sel)
      bucket = {2'b00, word[10:7]};
    else if (mid_sel)
      bucket = {1'b0, word[10:6]};
    else
      bucket = word[10:5];
  end
endmodule

// File: rtl/ibd_first_set.sv
module ibd_first_set #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/ibd_match_table.sv
module ibd_match_table
  import ibd_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int DEPTH = 1 << BKT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BKT_W-1:0]  wr_bucket,
  input  logic [SW-1:0]     wr_slot,
  input  logic [WORD_W-1:0] wr_opcode,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic [BKT_W-1:0]  rd_bucket,
  input  logic [WORD_W-1:0] rd_word,
  output logic              hit,
  output logic [SW-1:0]     hit_slot
);
  logic [SLOTS-1:0] slot_match;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      // Pattern storage: one write port, asynchronous read (LUT RAM friendly).
      logic [2*WORD_W-1:0] pat_mem [DEPTH];
      logic [DEPTH-1:0]    loaded;
      logic [2*WORD_W-1:0] pat_rd;
      logic                sel_wr;

      assign sel_wr = wr_en && (wr_slot == SW'(s));

      always_ff @(posedge clk) begin
        if (sel_wr) pat_mem[wr_bucket] <= {wr_opcode, wr_mask};
      end

      always_ff @(posedge clk) begin
        if (rst)         loaded <= '0;
        else if (sel_wr) loaded[wr_bucket] <= 1'b1;
      end

      assign pat_rd = pat_mem[rd_bucket];
      assign slot_match[s] = loaded[rd_bucket] &&
        ((rd_word & pat_rd[WORD_W-1:0]) == pat_rd[2*WORD_W-1:WORD_W]);
    end
  endgenerate

  ibd_first_set #(.N(SLOTS)) u_prio (
    .req (slot_match),
    .any (hit),
    .idx (hit_slot)
  );
endmodule

// File: rtl/insn_bucket_decode.sv
module insn_bucket_decode
  import ibd_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              tw_en,
  input  logic [BKT_W-1:0]  tw_bucket,
  input  logic [SW-1:0]     tw_slot,
  input  logic [WORD_W-1:0] tw_opcode,
  input  logic [WORD_W-1:0] tw_mask,
  output logic              res_valid,
  output logic [BKT_W-1:0]  res_bucket,
  output logic [F0_W-1:0]   res_f0,
  output logic [F1_W-1:0]   res_f1,
  output logic [F2_W-1:0]   res_f2,
  output logic              res_hit,
  output logic [SW-1:0]     res_slot,
  output logic              res_miss,
  output logic              res_zero
);
  logic [BKT_W-1:0] bkt_c;
  logic             hit_c;
  logic [SW-1:0]    slot_c;

  ibd_bucket_sel u_sel (
    .word   (in_word),
    .bucket (bkt_c)
  );

  ibd_match_table #(.SLOTS(SLOTS)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (tw_en),
    .wr_bucket (tw_bucket),
    .wr_slot   (tw_slot),
    .wr_opcode (tw_opcode),
    .wr_mask   (tw_mask),
    .rd_bucket (bkt_c),
    .rd_word   (in_word),
    .hit       (hit_c),
    .hit_slot  (slot_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
    end else begin
      res_valid <= in_valid;
      res_hit   <= in_valid && hit_c;
      res_miss  <= in_valid && !hit_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_bucket <= '0;
      res_f0     <= '0;
      res_f1     <= '0;
      res_f2     <= '0;
      res_slot   <= '0;
      res_zero   <= 1'b0;
    end else if (in_valid) begin
      res_bucket <= bkt_c;
      res_f0     <= in_word[4:0];
      res_f1     <= in_word[15:11];
      res_f2     <= in_word[31:16];
      res_slot   <= slot_c;
      res_zero   <= (in_word == '0);
    end
  end

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  // R5
  hold_bucket_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_bucket) && $stable(res_f2));
  // R7
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_hit, res_miss}));
  // R7
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_hit && !res_miss);
  // R8
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == '0) |=> res_zero && res_bucket == '0);
  // R4
  upper_field_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_f2 == $past(in_word[31:16]));
endmodule

// File: tb/test_insn_bucket_decode.sv
module test_insn_bucket_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        tw_en = 1'b0;
  logic [5:0]  tw_bucket = '0;
  logic [1:0]  tw_slot = '0;
  logic [31:0] tw_opcode = '0;
  logic [31:0] tw_mask = '0;
  logic        res_valid, res_hit, res_miss, res_zero;
  logic [5:0]  res_bucket;
  logic [4:0]  res_f0, res_f1;
  logic [15:0] res_f2;
  logic [1:0]  res_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  insn_bucket_decode i_insn_bucket_decode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .tw_en(tw_en), .tw_bucket(tw_bucket), .tw_slot(tw_slot),
    .tw_opcode(tw_opcode), .tw_mask(tw_mask),
    .res_valid(res_valid), .res_bucket(res_bucket), .res_f0(res_f0),
    .res_f1(res_f1), .res_f2(res_f2), .res_hit(res_hit), .res_slot(res_slot),
    .res_miss(res_miss), .res_zero(res_zero)
  );

  // {word, expected bucket, rule tag 1..3}
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {32'h0000_0040, 6'd2,  2'd1},
    {32'h0000_01E0, 6'd15, 2'd1},
    {32'h0000_02E0, 6'd23, 2'd1},
    {32'h0000_0620, 6'd49, 2'd1},
    {32'h0000_0700, 6'd56, 2'd1},
    {32'h0000_0760, 6'd59, 2'd1},
    {32'h0000_07C0, 6'd62, 2'd1},
    {32'h0000_07E0, 6'd63, 2'd1},
    {32'h0000_0300, 6'd6,  2'd2},
    {32'h0000_03E0, 6'd7,  2'd2},
    {32'h0000_0440, 6'd8,  2'd2},
    {32'h0000_05E0, 6'd11, 2'd2},
    {32'h0000_0780, 6'd30, 2'd3},
    {32'h0000_07A0, 6'd30, 2'd3}
  };

  task automatic chk(input bit ok, input string tag,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [5:0] b, input logic [1:0] s,
                      input logic [31:0] op, input logic [31:0] m);
    tw_en = 1'b1; tw_bucket = b; tw_slot = s; tw_opcode = op; tw_mask = m;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(res_valid == 1'b0, "R10 valid after reset", res_valid, 0);
    chk(res_hit == 1'b0 && res_miss == 1'b0, "R7 idle hit/miss", {res_hit, res_miss}, 0);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][39:8]);
      case (VEC[i][1:0])
        2'd1: chk(res_bucket == VEC[i][7:2], "R1 bucket", res_bucket, VEC[i][7:2]);
        2'd2: chk(res_bucket == VEC[i][7:2], "R2 bucket", res_bucket, VEC[i][7:2]);
        default: chk(res_bucket == VEC[i][7:2], "R3 bucket", res_bucket, VEC[i][7:2]);
      endcase
      chk(res_valid && res_miss && !res_hit, "R10 empty table miss", {res_valid, res_hit, res_miss}, 3'b101);
    end

    // R4 fields
    lookup(32'h1234_5B2D);
    chk(res_f0 == 5'h0D, "R4 f0", res_f0, 5'h0D);
    chk(res_f1 == 5'h0B, "R4 f1", res_f1, 5'h0B);
    chk(res_f2 == 16'h1234, "R4 f2", res_f2, 16'h1234);
    // R5 hold without strobe
    @(negedge clk);
    chk(!res_valid, "R5 valid drops", res_valid, 0);
    chk(res_f2 == 16'h1234 && res_f1 == 5'h0B, "R5 hold", res_f2, 16'h1234);

    // Bucket 6: slot0 misses, slot1 matches, slot2 catches all
    load(6'd6, 2'd0, 32'h0000_0380, 32'h0000_0780);
    load(6'd6, 2'd1, 32'h0000_0300, 32'h0000_0780);
    load(6'd6, 2'd2, 32'h0000_0000, 32'h0000_0000);
    lookup(32'h1234_5300);
    chk(res_hit && res_slot == 2'd1, "R6 first match slot1", res_slot, 1);
    chk(res_bucket == 6'd6 && res_f1 == 5'h0A, "R4 f1 on hit", res_f1, 5'h0A);

    // Bucket 7: slot0 narrow, slot1 empty, slot2 broad
    load(6'd7, 2'd0, 32'h0000_0381, 32'h0000_07FF);
    load(6'd7, 2'd2, 32'h00AB_0380, 32'hFFFF_0780);
    lookup(32'h00AB_0381);
    chk(res_hit && res_slot == 2'd0, "R6 both match -> slot0", res_slot, 0);
    lookup(32'h00AB_0382);
    chk(res_hit && res_slot == 2'd2, "R6 broad only -> slot2", res_slot, 2);
    lookup(32'h00AC_0382);
    chk(res_miss && !res_hit, "R7 no match miss", {res_hit, res_miss}, 1);

    // R9 overwrite slot0 with a pattern that no longer matches
    load(6'd7, 2'd0, 32'h0000_03FF, 32'h0000_07FF);
    lookup(32'h00AB_0381);
    chk(res_hit && res_slot == 2'd2, "R9 overwrite", res_slot, 2);

    // R9 same-cycle write is not visible to the lookup
    tw_en = 1'b1; tw_bucket = 6'd2; tw_slot = 2'd0;
    tw_opcode = 32'h0000_0040; tw_mask = 32'hFFFF_FFFF;
    lookup(32'h0000_0040);
    tw_en = 1'b0;
    chk(res_miss && !res_hit, "R9 same-cycle old view", {res_hit, res_miss}, 1);
    lookup(32'h0000_0040);
    chk(res_hit && res_slot == 2'd0, "R9 write then hit", {res_hit, res_slot}, 3'b100);

    // R8 zero word
    lookup(32'h0000_0000);
    chk(res_zero && res_bucket == 6'd0, "R8 zero flag", {res_zero, res_bucket}, 7'h40);
    lookup(32'h0000_0001);
    chk(!res_zero, "R8 nonzero", res_zero, 0);

    // R10 reset forgets the table
    do_reset();
    lookup(32'h00AB_0382);
    chk(res_miss && !res_hit, "R10 table cleared", {res_hit, res_miss}, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule